// File: doc/BRIEF.md
# Package Idle-State Resolver

This block chooses the idle power state of a whole multi-core package. Every core reports the idle depth it wants, and the package may go no deeper than its shallowest core. The platform sets a ceiling on depth, and it can also ask the package to stay shallower. When a configuration bit allows it, a heuristic hint may push the package one step deeper. The result is registered and may move from any idle state straight to any other.

Break events take priority over normal resolution. An interrupt that a core does not mask wakes that core and brings the package to the active state. A masked interrupt still wakes the target core long enough to deliver the event. A memory access or snoop is served with a one-cycle grant. In both of these cases the package wakes for one cycle and then returns to the state it held before the break. If the platform is asking for a shallower state at that moment, the package returns to that shallower state instead. The state before the break is kept in a register that only normal resolution writes.

Top module: `pkg_idle_resolver`

## Requirements
- R1: States use a 3-bit depth index: 0=C0 (active), 1=C1, 2=C3, 3=C6, 4=C7, 5=C8, 6=C9, 7=C10. A larger index means a deeper state. Reset clears `pkg_state` to 0 and clears `core_wake` and `mem_grant`. The stored state before a break also resets to 0.
- R2: Take a cycle with no break, with `hold_req` and demotion off, and with no return pending. One clock later `pkg_state` equals the smaller of the minimum over all `core_req` fields and `plat_limit`.
- R3: A change between two nonzero target depths moves `pkg_state` directly in one clock, without an intermediate 0.
- R4: With `demote_en` and `demote_hint` both high and a minimum request m with 1 <= m <= 6, the target becomes m+1 before the ceiling is applied. With `demote_en` low, `demote_hint` has no effect.
- R5: When `brk_core` is high and `brk_masked` is low, the next clock gives `pkg_state`=0 and a one-cycle strobe on `core_wake[brk_id]`. No return to the earlier state follows.
- R6: When `brk_core` and `brk_masked` are both high, the next clock gives `pkg_state`=0 and a strobe on `core_wake[brk_id]`. The clock after that restores the state that was held before the break.
- R7: When `brk_mem` is high, `mem_grant` pulses for exactly one cycle on the next clock. With no core break and no hold, the package goes to 0 for one cycle and then returns to its earlier state.
- R8: While `hold_req` is high, `hold_state` caps the target depth in normal resolution and also caps the state restored after a break.
- R9: A core break overrides a memory break in the same cycle for the package state. `mem_grant` is still issued.
- R10: `core_wake` is never high on more than one bit, and it is never high without a core break on the clock before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 3*NCORE | Requested depth per core, core i at bits [3i+2:3i] |
| plat_limit | input | 3 | Deepest depth the platform allows |
| hold_req | input | 1 | Platform asks for a shallower state |
| hold_state | input | 3 | Depth cap while `hold_req` is high |
| demote_en | input | 1 | Configuration enable for auto-demotion |
| demote_hint | input | 1 | Heuristic asks for one step deeper |
| brk_core | input | 1 | Interrupt break for one core |
| brk_masked | input | 1 | The core break is masked |
| brk_id | input | IDW | Target core of the break |
| brk_mem | input | 1 | Memory access or snoop break |
| pkg_state | output | 3 | Resolved package depth |
| core_wake | output | NCORE | One-cycle wake strobe per core |
| mem_grant | output | 1 | One-cycle service grant for memory or snoop |

## Verification
A wrong stored state before a break stays hidden until a masked or memory break occurs. It then shows on `pkg_state` two clocks after the break, as a wrong restored depth. A stuck return flag shows one clock later, either as a missing restore or as a restore where none was due. Errors in the minimum or the ceiling show on `pkg_state` one clock after the inputs change. For that reason the bench compares every cycle, including cycles of random break traffic.

// File: rtl/pkg_idle_resolver.sv
module pkg_idle_resolver #(
  parameter int NCORE = 4,
  parameter int IDW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3*NCORE-1:0] core_req,
  input  logic [2:0]         plat_limit,
  input  logic               hold_req,
  input  logic [2:0]         hold_state,
  input  logic               demote_en,
  input  logic               demote_hint,
  input  logic               brk_core,
  input  logic               brk_masked,
  input  logic [IDW-1:0]     brk_id,
  input  logic               brk_mem,
  output logic [2:0]         pkg_state,
  output logic [NCORE-1:0]   core_wake,
  output logic               mem_grant
);
  logic [2:0] min_req, demoted, hold_cap, ceiling, target, ret_target, prev_q;
  logic       ret_q;

  always_comb begin
    min_req = 3'd7;
    for (int i = 0; i < NCORE; i++)
      if (core_req[3*i +: 3] < min_req) min_req = core_req[3*i +: 3];
  end

  assign demoted    = (demote_en && demote_hint && min_req != 3'd0 && min_req != 3'd7)
                      ? min_req + 3'd1 : min_req;
  assign hold_cap   = hold_req ? hold_state : 3'd7;
  assign ceiling    = (plat_limit < hold_cap) ? plat_limit : hold_cap;
  assign target     = (demoted < ceiling) ? demoted : ceiling;
  assign ret_target = (prev_q < hold_cap) ? prev_q : hold_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkg_state <= 3'd0;
      prev_q    <= 3'd0;
      ret_q     <= 1'b0;
      core_wake <= '0;
      mem_grant <= 1'b0;
    end else begin
      core_wake <= '0;
      mem_grant <= brk_mem;
      if (brk_core) begin
        if (32'(brk_id) < NCORE) core_wake[brk_id] <= 1'b1;
        pkg_state <= 3'd0;
        ret_q     <= brk_masked;
      end else if (brk_mem) begin
        pkg_state <= 3'd0;
        ret_q     <= 1'b1;
      end else if (ret_q) begin
        pkg_state <= ret_target;
        ret_q     <= 1'b0;
      end else begin
        pkg_state <= target;
        prev_q    <= target;
      end
    end
  end
endmodule

module pkg_idle_resolver_chk #(
  parameter int NCORE = 4,
  parameter int IDW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk_core,
  input logic             brk_masked,
  input logic             brk_mem,
  input logic [2:0]       pkg_state,
  input logic [NCORE-1:0] core_wake,
  input logic             mem_grant
);
  p_wake_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_wake));
  p_wake_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_wake) |-> $past(brk_core));
  p_unmasked_c0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_core && !brk_masked) |=> (pkg_state == 3'd0 && $countones(core_wake) == 1));
  p_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_mem |=> mem_grant);
  p_grant_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant |-> $past(brk_mem));
  p_break_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_core || brk_mem) |=> pkg_state == 3'd0);
endmodule

bind pkg_idle_resolver pkg_idle_resolver_chk #(.NCORE(NCORE), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_core(brk_core), .brk_masked(brk_masked),
  .brk_mem(brk_mem), .pkg_state(pkg_state), .core_wake(core_wake), .mem_grant(mem_grant)
);

// File: tb/pkg_idle_resolver_bench.sv
module pkg_idle_resolver_bench;
  localparam int NC = 4;
  logic clk = 0, rst_n = 0;
  logic [3*NC-1:0] core_req = '0;
  logic [2:0] plat_limit = 3'd7, hold_state = 3'd0;
  logic hold_req = 0, demote_en = 0, demote_hint = 0;
  logic brk_core = 0, brk_masked = 0, brk_mem = 0;
  logic [1:0] brk_id = 0;
  logic [2:0] pkg_state;
  logic [NC-1:0] core_wake;
  logic mem_grant;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [2:0] m_pkg = 0, m_prev = 0;
  logic m_ret = 0, m_grant = 0;
  logic [NC-1:0] m_wake = 0;

  always #10 clk = ~clk;

  pkg_idle_resolver #(.NCORE(NC)) u_pkg_idle_resolver (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .plat_limit(plat_limit),
    .hold_req(hold_req), .hold_state(hold_state), .demote_en(demote_en),
    .demote_hint(demote_hint), .brk_core(brk_core), .brk_masked(brk_masked),
    .brk_id(brk_id), .brk_mem(brk_mem), .pkg_state(pkg_state),
    .core_wake(core_wake), .mem_grant(mem_grant));

  function automatic logic [2:0] min3(input logic [2:0] a, input logic [2:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [2:0] want_target();
    logic [2:0] m = 3'd7;
    for (int i = 0; i < NC; i++) m = min3(m, core_req[3*i +: 3]);
    if (demote_en && demote_hint && m >= 3'd1 && m <= 3'd6) m = m + 3'd1;
    m = min3(m, plat_limit);
    if (hold_req) m = min3(m, hold_state);
    return m;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    m_wake = '0;
    m_grant = brk_mem;
    if (brk_core) begin
      m_wake[brk_id] = 1'b1; m_pkg = 0; m_ret = brk_masked;
    end else if (brk_mem) begin
      m_pkg = 0; m_ret = 1;
    end else if (m_ret) begin
      m_pkg = hold_req ? min3(m_prev, hold_state) : m_prev; m_ret = 0;
    end else begin
      m_pkg = want_target(); m_prev = m_pkg;
    end
    @(negedge clk);
    check({tag, " pkg"}, pkg_state, m_pkg);
    check({tag, " wake"}, core_wake, m_wake);
    check({tag, " grant"}, mem_grant, m_grant);
  endtask

  task automatic quiet();
    brk_core = 0; brk_masked = 0; brk_mem = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset pkg", pkg_state, 0);
    check("R1 reset wake", core_wake, 0);
    check("R1 reset grant", mem_grant, 0);
    rst_n = 1;

    core_req = {3'd5, 3'd6, 3'd4, 3'd7}; plat_limit = 3'd7;
    step("R2 min");
    check("R2 min value", pkg_state, 4);
    plat_limit = 3'd2;
    step("R2 ceiling");
    check("R2 ceiling value", pkg_state, 2);
    plat_limit = 3'd7; step("R3 setup");
    core_req = {3'd5, 3'd6, 3'd6, 3'd7};
    step("R3 direct");
    check("R3 direct no C0", pkg_state, 5);

    demote_hint = 1; step("R4 disabled hint");
    check("R4 hint ignored", pkg_state, 5);
    demote_en = 1; step("R4 demote");
    check("R4 demoted", pkg_state, 6);
    demote_en = 0; demote_hint = 0; step("R4 off");

    brk_core = 1; brk_id = 2; step("R5 unmasked");
    check("R5 pkg C0", pkg_state, 0);
    check("R5 wake core2", core_wake, 4);
    quiet(); core_req = '0; step("R5 stays");
    check("R5 no return", pkg_state, 0);
    core_req = {3'd3, 3'd3, 3'd3, 3'd3}; step("R6 setup");
    brk_core = 1; brk_masked = 1; brk_id = 1; step("R6 masked");
    check("R6 C0", pkg_state, 0);
    quiet(); core_req = '0; step("R6 return");
    check("R6 restored", pkg_state, 3);

    core_req = {3'd6, 3'd6, 3'd6, 3'd6}; step("R7 setup");
    brk_mem = 1; step("R7 mem");
    check("R7 grant", mem_grant, 1);
    quiet(); step("R7 return");
    check("R7 restored", pkg_state, 6);
    check("R7 grant one cycle", mem_grant, 0);

    brk_mem = 1; step("R8 mem");
    quiet(); hold_req = 1; hold_state = 3'd1; step("R8 return");
    check("R8 held shallow", pkg_state, 1);
    step("R8 normal"); check("R8 cap normal", pkg_state, 1);
    hold_req = 0; step("R8 release");

    brk_mem = 1; brk_core = 1; brk_id = 3; step("R9 both");
    check("R9 core wins wake", core_wake, 8);
    check("R9 grant too", mem_grant, 1);
    quiet(); step("R9 after");
    check("R9 unmasked no return", pkg_state, 6);

    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NC; i++) core_req[3*i +: 3] = 3'($urandom);
      plat_limit = 3'($urandom);
      hold_req = ($urandom % 4) == 0; hold_state = 3'($urandom);
      demote_en = $urandom; demote_hint = $urandom;
      brk_core = ($urandom % 6) == 0; brk_masked = $urandom;
      brk_id = 2'($urandom); brk_mem = ($urandom % 6) == 0;
      step("R2-R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule